// File: doc/BRIEF.md
# I2C Register-Access Master

This block is the only master on a two-wire serial bus and moves one byte to or from a register of a target device. The host pulses a write or read request together with an 8-bit address byte (the 7-bit device address in bits 7..1), a register index and, for writes, a value. The block then plays out the whole bus sequence alone and answers with a one-cycle completion pulse, an error code and, for reads, the received byte.

The clock line is driven directly. The data line is open-drain: the block only ever pulls it low through an output enable, and it reads the wire back through a sampled input. All bus timing is measured in base ticks. One tick lasts `CLK_DIV` system clocks, and a full clock-high phase lasts `HOLD_TICKS` ticks.

Any acknowledge that is missing makes the block finish the attempt with a stop and then replay the whole transaction from a fresh start condition. It makes at most `MAX_TRY` attempts. Only the result of the final attempt is reported.

Top module: `i2c_regx_master`

## Requirements
- R1: After reset, and whenever idle, the clock line is high, the data line is released (`sda_oe`=0), and `busy` and `done` are low.
- R2: A write attempt runs: start; address byte with bit 0 forced to 0; acknowledge slot; register byte; acknowledge slot; value byte; acknowledge slot; stop.
- R3: The write error code is a 3-bit mask from the final attempt. Bit 0 set means the address was not acknowledged, bit 1 the register byte, and bit 2 the value byte. It is 0 when all three were acknowledged.
- R4: A read attempt runs: start; address byte with bit 0 cleared; acknowledge slot; register byte; acknowledge slot; a clock-low idle of H ticks with data released; repeated start; address byte with bit 0 set; acknowledge slot; eight received bits; one NACK slot with data released; stop. `rd_data` holds the received byte, first bit in bit 7, when `done` pulses.
- R5: For a read, `err` bit 0 is set when any of its three acknowledges failed on the final attempt. Bits 2..1 are always 0.
- R6: When an attempt has any failed acknowledge, the block runs the full stop sequence and then restarts from the start condition. It makes at most `MAX_TRY` attempts in total (default 4).
- R7: Bytes are sent most significant bit first. While the clock stays high, the data line changes only inside a start or stop condition.
- R8: Timing uses H = `HOLD_TICKS` ticks of `CLK_DIV` clocks each. Start: clock and data high for H, data low for H, clock low for H. Each bit or acknowledge slot: clock low H/2, clock high H, clock low H/2, with data constant through the slot. Stop: clock and data low for 2H, clock high for 2H, data released for H.
- R9: In each acknowledge slot the data line is released. The slot counts as acknowledged when the line is sampled low on the last system clock of its clock-high phase.
- R10: `busy` rises on the clock after an accepted request and stays high until the transaction ends. `done` is a one-cycle pulse on the first cycle with `busy` low. Requests that arrive while `busy` is high are ignored.
- R11: A request is accepted only while idle. If `req_wr` and `req_rd` arrive in the same cycle, the write is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr | input | 1 | Pulse to start a register write |
| req_rd | input | 1 | Pulse to start a register read |
| dev_addr | input | 8 | Address byte; device address in bits 7..1 |
| reg_idx | input | 8 | Register index sent after the address |
| wr_val | input | 8 | Value to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 3 | Failed-acknowledge code of the final attempt |
| rd_data | output | 8 | Received byte, valid with `done` |
| scl_o | output | 1 | Bus clock line |
| sda_oe | output | 1 | Pull data line low when 1 |
| sda_i | input | 1 | Sampled level of the data line |

## Verification
The assertions assume that `sda_i` is already synchronous to `clk` and that it reflects this block's own pull-down whenever `sda_oe` is high. They also assume the target changes the line only while the clock is low, and that requests are single-cycle pulses. The stimulus builds the target's pull-down from the bench's own timeline of bus segments and changes it only at falling clock edges inside clock-low segments. It sends an extra pair of requests with different operands partway through one read, to check that they are ignored.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
   // Phase of the current program step
   typedef enum logic [2:0] {
      K_START = 3'd0,
      K_GAP   = 3'd1,
      K_TX    = 3'd2,
      K_RX    = 3'd3,
      K_STOP  = 3'd4
   } kind_e;

   // Segment length class: half, one or two clock-high periods
   typedef enum logic [1:0] {
      LEN_HALF = 2'd0,
      LEN_FULL = 2'd1,
      LEN_DBL  = 2'd2
   } len_e;

   typedef struct packed {
      logic scl;
      logic pull;
      len_e len;
   } seg_t;
endpackage

// File: rtl/i2cr_tick.sv
module i2cr_tick #(
   parameter int CLK_DIV    = 4,
   parameter int HOLD_TICKS = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           run,
   input  i2cr_pkg::len_e len,
   output logic           seg_end
);
   import i2cr_pkg::*;

   localparam int HALF_T = HOLD_TICKS / 2;
   localparam int DBL_T  = 2 * HOLD_TICKS;
   localparam int TW     = $clog2(DBL_T);

   if (CLK_DIV < 1) begin : g_bad_div
      $error("CLK_DIV must be at least 1");
   end
   if (HOLD_TICKS < 2 || (HOLD_TICKS % 2) != 0) begin : g_bad_hold
      $error("HOLD_TICKS must be even and at least 2");
   end

   logic          tick;
   logic [TW-1:0] tcnt;
   logic [TW-1:0] tlim;

   generate
      if (CLK_DIV == 1) begin : g_nodiv
         assign tick = run;
      end else begin : g_div
         localparam int DW = $clog2(CLK_DIV);
         logic [DW-1:0] dcnt;
         always_ff @(posedge clk) begin
            if (!rst_n)             dcnt <= '0;
            else if (!run || tick)  dcnt <= '0;
            else                    dcnt <= dcnt + DW'(1);
         end
         assign tick = run && (dcnt == DW'(CLK_DIV - 1));
      end
   endgenerate

   always_comb begin
      unique case (len)
         LEN_HALF: tlim = TW'(HALF_T - 1);
         LEN_DBL:  tlim = TW'(DBL_T - 1);
         default:  tlim = TW'(HOLD_TICKS - 1);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)               tcnt <= '0;
      else if (!run || seg_end) tcnt <= '0;
      else if (tick)            tcnt <= tcnt + TW'(1);
   end

   assign seg_end = tick && (tcnt == tlim);

   // R8: the tick count never passes the limit of the running segment
   p_tick_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !$past(seg_end) && $stable(len)) |-> (tcnt <= tlim));
endmodule

// File: rtl/i2cr_segdesc.sv
module i2cr_segdesc (
   input  i2cr_pkg::kind_e kind,
   input  logic [3:0]      bitn,
   input  logic [1:0]      sub,
   input  logic            txbit,
   output i2cr_pkg::seg_t  seg,
   output logic            last_sub
);
   import i2cr_pkg::*;

   logic bitv;

   always_comb begin
      bitv     = ((kind == K_TX) && (bitn != 4'd8)) ? txbit : 1'b1;
      seg      = '{scl: 1'b1, pull: 1'b0, len: LEN_FULL};
      last_sub = (sub == 2'd2);
      unique case (kind)
         K_START: begin
            case (sub)
               2'd0:    seg = '{scl: 1'b1, pull: 1'b0, len: LEN_FULL};
               2'd1:    seg = '{scl: 1'b1, pull: 1'b1, len: LEN_FULL};
               default: seg = '{scl: 1'b0, pull: 1'b1, len: LEN_FULL};
            endcase
         end
         K_GAP: begin
            seg      = '{scl: 1'b0, pull: 1'b0, len: LEN_FULL};
            last_sub = 1'b1;
         end
         K_TX, K_RX: begin
            if (sub == 2'd1) seg = '{scl: 1'b1, pull: !bitv, len: LEN_FULL};
            else             seg = '{scl: 1'b0, pull: !bitv, len: LEN_HALF};
         end
         K_STOP: begin
            case (sub)
               2'd0:    seg = '{scl: 1'b0, pull: 1'b1, len: LEN_DBL};
               2'd1:    seg = '{scl: 1'b1, pull: 1'b1, len: LEN_DBL};
               default: seg = '{scl: 1'b1, pull: 1'b0, len: LEN_FULL};
            endcase
         end
         default: begin
            seg      = '{scl: 1'b1, pull: 1'b0, len: LEN_FULL};
            last_sub = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/i2cr_seq.sv
module i2cr_seq #(
   parameter int MAX_TRY = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_wr,
   input  logic            req_rd,
   input  logic [7:0]      dev_addr,
   input  logic [7:0]      reg_idx,
   input  logic [7:0]      wr_val,
   input  logic            sda_i,
   input  logic            seg_end,
   input  logic            last_sub,
   output logic            run,
   output i2cr_pkg::kind_e kind,
   output logic [3:0]      bitn,
   output logic [1:0]      sub,
   output logic            txbit,
   output logic            op_rd,
   output logic            done,
   output logic [2:0]      err,
   output logic [7:0]      rd_data
);
   import i2cr_pkg::*;

   localparam int TRY_W = (MAX_TRY > 1) ? $clog2(MAX_TRY) : 1;

   if (MAX_TRY < 1) begin : g_bad_try
      $error("MAX_TRY must be at least 1");
   end

   logic [2:0]       step;
   logic [TRY_W-1:0] tries;
   logic [2:0]       errm;
   logic [2:0]       fail_bit;
   logic [7:0]       shreg, rxsh, addr_q, reg_q, val_q;

   function automatic kind_e kind_of(input logic rd, input logic [2:0] st);
      kind_e k;
      if (!rd) begin
         case (st)
            3'd0:             k = K_START;
            3'd1, 3'd2, 3'd3: k = K_TX;
            default:          k = K_STOP;
         endcase
      end else begin
         case (st)
            3'd0, 3'd4:       k = K_START;
            3'd1, 3'd2, 3'd5: k = K_TX;
            3'd3:             k = K_GAP;
            3'd6:             k = K_RX;
            default:          k = K_STOP;
         endcase
      end
      return k;
   endfunction

   function automatic logic [7:0] byte_of(input logic rd, input logic [2:0] st,
                                          input logic [7:0] a, input logic [7:0] r,
                                          input logic [7:0] v);
      logic [7:0] b;
      case (st)
         3'd1:    b = a & 8'hFE;
         3'd2:    b = r;
         3'd3:    b = rd ? 8'h00 : v;
         3'd5:    b = a | 8'h01;
         default: b = 8'h00;
      endcase
      return b;
   endfunction

   assign kind     = kind_of(op_rd, step);
   assign txbit    = shreg[7];
   assign fail_bit = op_rd ? 3'b001 : (3'b001 << (step - 3'd1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run     <= 1'b0;
         op_rd   <= 1'b0;
         step    <= '0;
         bitn    <= '0;
         sub     <= '0;
         tries   <= '0;
         errm    <= '0;
         shreg   <= '0;
         rxsh    <= '0;
         addr_q  <= '0;
         reg_q   <= '0;
         val_q   <= '0;
         done    <= 1'b0;
         err     <= '0;
         rd_data <= '0;
      end else begin
         done <= 1'b0;
         if (!run) begin
            if (req_wr || req_rd) begin
               run    <= 1'b1;
               op_rd  <= !req_wr;
               addr_q <= dev_addr;
               reg_q  <= reg_idx;
               val_q  <= wr_val;
               step   <= '0;
               bitn   <= '0;
               sub    <= '0;
               tries  <= '0;
               errm   <= '0;
            end
         end else if (seg_end) begin
            if (kind == K_TX && bitn == 4'd8 && sub == 2'd1 && sda_i)
               errm <= errm | fail_bit;
            if (kind == K_RX && bitn != 4'd8 && sub == 2'd1)
               rxsh <= {rxsh[6:0], sda_i};
            if (!last_sub) begin
               sub <= sub + 2'd1;
            end else begin
               sub <= '0;
               if ((kind == K_TX || kind == K_RX) && bitn != 4'd8) begin
                  bitn  <= bitn + 4'd1;
                  shreg <= {shreg[6:0], 1'b0};
               end else begin
                  bitn <= '0;
                  if (kind == K_STOP) begin
                     if (errm != 3'b000 && tries != TRY_W'(MAX_TRY - 1)) begin
                        tries <= tries + TRY_W'(1);
                        errm  <= '0;
                        step  <= '0;
                     end else begin
                        run     <= 1'b0;
                        done    <= 1'b1;
                        err     <= errm;
                        rd_data <= rxsh;
                     end
                  end else begin
                     step  <= step + 3'd1;
                     shreg <= byte_of(op_rd, step + 3'd1, addr_q, reg_q, val_q);
                  end
               end
            end
         end
      end
   end

   p_try_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (tries <= TRY_W'(MAX_TRY - 1)));
   p_read_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_rd) |-> (err[2:1] == 2'b00));
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_after_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!run && $past(run)));
   p_write_steps_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !op_rd) |-> (step <= 3'd4));
endmodule

// File: rtl/i2c_regx_master.sv
module i2c_regx_master #(
   parameter int CLK_DIV    = 4,
   parameter int HOLD_TICKS = 8,
   parameter int MAX_TRY    = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_wr,
   input  logic       req_rd,
   input  logic [7:0] dev_addr,
   input  logic [7:0] reg_idx,
   input  logic [7:0] wr_val,
   output logic       busy,
   output logic       done,
   output logic [2:0] err,
   output logic [7:0] rd_data,
   output logic       scl_o,
   output logic       sda_oe,
   input  logic       sda_i
);
   import i2cr_pkg::*;

   logic       run, seg_end, last_sub, txbit, op_rd;
   kind_e      kind;
   logic [3:0] bitn;
   logic [1:0] sub;
   seg_t       seg;

   i2cr_seq #(.MAX_TRY(MAX_TRY)) u_seq (
      .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_rd(req_rd),
      .dev_addr(dev_addr), .reg_idx(reg_idx), .wr_val(wr_val),
      .sda_i(sda_i), .seg_end(seg_end), .last_sub(last_sub),
      .run(run), .kind(kind), .bitn(bitn), .sub(sub), .txbit(txbit),
      .op_rd(op_rd), .done(done), .err(err), .rd_data(rd_data)
   );

   i2cr_segdesc u_desc (
      .kind(kind), .bitn(bitn), .sub(sub), .txbit(txbit),
      .seg(seg), .last_sub(last_sub)
   );

   i2cr_tick #(.CLK_DIV(CLK_DIV), .HOLD_TICKS(HOLD_TICKS)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(run), .len(seg.len), .seg_end(seg_end)
   );

   assign busy   = run;
   assign scl_o  = run ? seg.scl  : 1'b1;
   assign sda_oe = run ? seg.pull : 1'b0;

   p_sda_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && scl_o && $past(scl_o) && !$stable(sda_oe))
      |-> (kind == K_START || kind == K_STOP));
   p_ack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && kind == K_TX && bitn == 4'd8) |-> !sda_oe);
   p_rx_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && kind == K_RX) |-> !sda_oe);
   p_read_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && $past(req_wr)) |-> !op_rd);
endmodule

// File: tb/i2c_regx_master_bench.sv
module i2c_regx_master_bench;
   localparam int DIV   = 4;
   localparam int HOLD  = 8;
   localparam int TRIES = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_wr = 1'b0, req_rd = 1'b0;
   logic [7:0] dev_addr = '0, reg_idx = '0, wr_val = '0;
   logic       busy, done, scl_o, sda_oe, sda_i;
   logic [2:0] err;
   logic [7:0] rd_data;
   logic       tgt_low = 1'b0;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;
   assign sda_i = ~(sda_oe | tgt_low);

   i2c_regx_master #(.CLK_DIV(DIV), .HOLD_TICKS(HOLD), .MAX_TRY(TRIES)) u_i2c_regx_master (
      .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_rd(req_rd),
      .dev_addr(dev_addr), .reg_idx(reg_idx), .wr_val(wr_val),
      .busy(busy), .done(done), .err(err), .rd_data(rd_data),
      .scl_o(scl_o), .sda_oe(sda_oe), .sda_i(sda_i)
   );

   typedef struct { bit scl; bit pull; int clks; bit tgt; } wseg_t;
   wseg_t plan[$];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic push(input bit scl, input bit pull, input int ticks, input bit tgt);
      wseg_t s;
      s.scl = scl; s.pull = pull; s.clks = ticks * DIV; s.tgt = tgt;
      plan.push_back(s);
   endtask

   task automatic add_start();
      push(1, 0, HOLD, 0); push(1, 1, HOLD, 0); push(0, 1, HOLD, 0);
   endtask
   task automatic add_stop();
      push(0, 1, 2*HOLD, 0); push(1, 1, 2*HOLD, 0); push(1, 0, HOLD, 0);
   endtask
   task automatic add_slot(input bit pull, input bit tgt);
      push(0, pull, HOLD/2, tgt); push(1, pull, HOLD, tgt); push(0, pull, HOLD/2, tgt);
   endtask
   task automatic add_tx(input logic [7:0] b, input bit acked);
      for (int i = 7; i >= 0; i--) add_slot(!b[i], 0);
      add_slot(0, acked);
   endtask
   task automatic add_rx(input logic [7:0] d);
      for (int i = 7; i >= 0; i--) add_slot(0, !d[i]);
      add_slot(0, 0);
   endtask

   // nak_plan bits [3a+2:3a] list the acknowledges the target withholds on attempt a
   task automatic run_txn(input bit use_wr, input bit use_rd, input logic [7:0] a,
                          input logic [7:0] r, input logic [7:0] v,
                          input logic [11:0] nak_plan, input logic [7:0] rxd,
                          input bit poke, input string tag);
      bit rd;
      logic [2:0] eerr, nk;
      int n, miss;
      logic [3:0] fa, fe, ac, ex;
      rd = !use_wr;
      plan.delete();
      eerr = '0;
      for (int t = 0; t < TRIES; t++) begin
         nk = nak_plan[3*t +: 3];
         add_start();
         add_tx(a & 8'hFE, !nk[0]);
         add_tx(r, !nk[1]);
         if (!rd) begin
            add_tx(v, !nk[2]);
            eerr = nk;
         end else begin
            push(0, 0, HOLD, 0);
            add_start();
            add_tx(a | 8'h01, !nk[2]);
            add_rx(rxd);
            eerr = {2'b00, |nk};
         end
         add_stop();
         if (nk == 3'b000) break;
      end
      @(negedge clk);
      req_wr = use_wr; req_rd = use_rd;
      dev_addr = a; reg_idx = r; wr_val = v;
      @(posedge clk);
      n = 0; miss = 0; fa = '0; fe = '0;
      foreach (plan[k]) begin
         for (int c = 0; c < plan[k].clks; c++) begin
            @(negedge clk);
            if (n == 0) begin req_wr = 0; req_rd = 0; end
            if (poke && n == 40) begin
               req_wr = 1; req_rd = 1; dev_addr = 8'h00; reg_idx = ~r; wr_val = ~v;
            end
            if (poke && n == 41) begin req_wr = 0; req_rd = 0; end
            tgt_low = plan[k].tgt;
            ac = {busy, scl_o, sda_oe, done};
            ex = {1'b1, plan[k].scl, plan[k].pull, 1'b0};
            if (ac !== ex) begin
               if (miss == 0) begin fa = ac; fe = ex; end
               miss++;
            end
            n++;
         end
      end
      @(negedge clk);
      tgt_low = 0;
      chk({tag, " bus waveform {busy,scl,oe,done}"}, 32'(fa), 32'(fe));
      chk({tag, " R10 done pulse {busy,done}"}, {30'd0, busy, done}, 32'h1);
      chk({tag, " error code R3/R5"}, 32'(err), 32'(eerr));
      if (rd) chk({tag, " R4 read data"}, 32'(rd_data), 32'(rxd));
      @(negedge clk);
      chk({tag, " R10 idle after done, R1 lines"}, {28'd0, busy, done, scl_o, sda_oe}, 32'b0010);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL R10 watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset {busy,done,scl,oe}", {28'd0, busy, done, scl_o, sda_oe}, 32'b0010);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 idle after reset {busy,done,scl,oe}", {28'd0, busy, done, scl_o, sda_oe}, 32'b0010);

      // R2 R7 R8: clean write, address bit 0 must be forced low
      run_txn(1, 0, 8'hA1, 8'h5C, 8'h96, 12'h000, 8'h00, 0, "R2/R7/R8 write");
      // R4 R10: clean read with ignored requests during busy
      run_txn(0, 1, 8'h3A, 8'h07, 8'h00, 12'h000, 8'hC5, 1, "R4/R10 read");
      // R6 R9: register byte not acknowledged once, second attempt succeeds
      run_txn(1, 0, 8'h44, 8'h12, 8'hF0, 12'b000_000_000_010, 8'h00, 0, "R6/R9 write retry");
      // R3 R6: value byte never acknowledged, four attempts, mask 100
      run_txn(1, 0, 8'h60, 8'hAA, 8'h55, {4{3'b100}}, 8'h00, 0, "R3/R6 write data nak");
      // R3: mask taken from final attempt only
      run_txn(1, 0, 8'h2E, 8'h81, 8'h7E, {3'b011, 3'b010, 3'b011, 3'b001}, 8'h00, 0, "R3 write mixed naks");
      // R5 R6: read address phase never acknowledged
      run_txn(0, 1, 8'h90, 8'h33, 8'h00, {4{3'b100}}, 8'h5A, 0, "R5/R6 read nak");
      // R11: simultaneous requests resolve to a write
      run_txn(1, 1, 8'h52, 8'h81, 8'h3C, 12'h000, 8'h00, 0, "R11 both requests");
      // R6 R4: read retried after address nak, then clean
      run_txn(0, 1, 8'h1C, 8'hE4, 8'h00, 12'b000_000_000_001, 8'h0F, 0, "R6/R4 read retry");

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule